// File: doc/BRIEF.md
# NAND Boot Page Fallback Sequencer

This block fetches a bootstrap image from NAND flash after reset, with no software involved. It asks a simple page-read engine for one page at a time from a fixed list of candidate page addresses. The first candidate is page 0, and each later candidate is a fixed stride further on. The engine returns the whole physical page as 64-bit beats, and the spare area is included. A page-done pulse then carries the page's uncorrectable-ECC flag.

The data-area beats go straight to an image write port with an incrementing word address. The spare-area beats are consumed and dropped. A 32-bit additive checksum runs over the data area.

A page is rejected when its ECC flag is set or when its beat count is wrong, and the sequencer then tries the next candidate. If every candidate is rejected, the block stops requesting pages and raises a sticky failure flag. If a page arrives clean but its checksum does not match the expected value, the whole sequence starts again from page 0, as a reboot would. A saturating counter reports how many such restarts have occurred. A checksum match raises a sticky success flag.

Top module: `nand_boot_fetch`

## Requirements
- R1: After reset is released, the first page request names page 0. Successive candidates are requested strictly in the order 0, 256, 512, 768 (candidate k is page k*256).
- R2: When the page-done pulse arrives with page_ecc_fail high, the current candidate is rejected and the next candidate is requested.
- R3: A page whose accepted beat count at page-done differs from 264 (for example 200 or 270 beats) is rejected like an ECC failure, even with page_ecc_fail low.
- R4: After all four candidates have been rejected, boot_fail goes high and stays high until reset. From then on req_valid and beat_ready stay low and no image writes occur.
- R5: Of the 264 beats of a page, only the first 256 are written to the image port. Each is written in the cycle it is accepted, with img_addr equal to its beat index (0 to 255) and img_wdata equal to beat_data. The last 8 spare-area beats produce no write.
- R6: The checksum is the modulo-2^32 sum of the 512 little-endian 32-bit words of the data area, where bits 31:0 of each beat are the lower word and bits 63:32 the upper word. For a page that is not rejected, a sum equal to exp_csum makes boot_ok go high one cycle after page-done. boot_ok then stays high, and no further requests are issued.
- R7: For a page that is not rejected, a checksum that differs from exp_csum restarts the sequence at page 0 and increments restart_cnt. The counter saturates at its all-ones value (15 for the default 4-bit width).
- R8: Only one page read is outstanding at a time: no new request is raised before page-done. While req_valid is high and req_ready is low, req_page holds steady.
- R9: While reset is high, req_valid, beat_ready, img_we, boot_ok and boot_fail are low and restart_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Page read request valid |
| req_ready | input | 1 | Page-read engine accepts the request |
| req_page | output | PAGE_AW (24) | Page address of the request |
| beat_valid | input | 1 | Data beat valid |
| beat_ready | output | 1 | Data beat accepted (high during a transfer) |
| beat_data | input | 64 | Data beat, 8 bytes |
| page_done | input | 1 | One-cycle pulse after the last beat of a page |
| page_ecc_fail | input | 1 | Uncorrectable ECC status, qualified by page_done |
| exp_csum | input | 32 | Expected image checksum |
| img_we | output | 1 | Image write strobe |
| img_addr | output | 8 | Image word address (beat index) |
| img_wdata | output | 64 | Image write data |
| boot_ok | output | 1 | Sticky: image loaded and checksum matched |
| boot_fail | output | 1 | Sticky: all candidates rejected |
| restart_cnt | output | RESTART_W (4) | Saturating count of checksum restarts |

## Verification
The assertions check the following on every cycle:
- the request stays steady under back-pressure;
- a rejected page is followed by the next candidate at one stride further on;
- a checksum mismatch is followed by a request for page 0;
- image writes happen only for accepted beats;
- boot_ok and boot_fail never both hold, and each stays high once set;
- the restart count never decreases;
- the checksum register holds when no data arrives.

Only the bench's scenarios can show that the checksum value itself is right. The same holds for the exact 264-beat limit, the dropping of the spare area, saturation of the restart counter, and how a mixed series of ECC errors, short and long pages and mismatches plays out.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

    localparam int BEAT_W = 64;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_REQ,
        ST_XFER,
        ST_OK,
        ST_FAIL
    } boot_state_e;

    typedef enum logic [1:0] {
        VERDICT_BAD,
        VERDICT_MISMATCH,
        VERDICT_MATCH
    } page_verdict_e;

    typedef struct packed {
        logic        we;
        logic [63:0] data;
    } beat_fwd_t;

    function automatic logic [WORD_W-1:0] beat_word_sum(input logic [BEAT_W-1:0] d);
        return d[WORD_W-1:0] + d[BEAT_W-1:WORD_W];
    endfunction

    function automatic page_verdict_e classify(input logic bad, input logic match);
        if (bad)
            return VERDICT_BAD;
        else if (match)
            return VERDICT_MATCH;
        else
            return VERDICT_MISMATCH;
    endfunction

endpackage

// File: rtl/nbf_beat_router.sv
module nbf_beat_router
    import nbf_pkg::*;
#(
    parameter int DATA_BEATS = 256,
    parameter int PAGE_BEATS = 264,
    localparam int IMG_AW = $clog2(DATA_BEATS),
    localparam int CNT_W = $clog2(PAGE_BEATS + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_active,
    input  logic              page_start,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_data,
    output logic              beat_ready,
    output logic              img_we,
    output logic [IMG_AW-1:0] img_addr,
    output logic [BEAT_W-1:0] img_wdata,
    output logic              count_ok
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE_BEATS);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(DATA_BEATS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             accept;
    beat_fwd_t        fwd;

    assign beat_ready = xfer_active;
    assign accept     = beat_valid && xfer_active;

    always_comb begin
        cnt_next = cnt_q;
        if (accept && cnt_q != CNT_MAX)
            cnt_next = cnt_q + 1'b1;
    end

    // Beat accepted in the page-done cycle still counts toward the total.
    assign count_ok = (cnt_next == CNT_PAGE);

    always_comb begin
        fwd.we   = accept && (cnt_q < CNT_DATA);
        fwd.data = beat_data;
    end

    assign img_we    = fwd.we;
    assign img_wdata = fwd.data;
    assign img_addr  = cnt_q[IMG_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || page_start)
            cnt_q <= '0;
        else
            cnt_q <= cnt_next;
    end

    // R5: a write only happens for a beat that was accepted
    assert_write_accepted_R5: assert property (@(posedge clk) disable iff (rst)
        img_we |-> (beat_valid && beat_ready));

    // R5: consecutive data writes step the address by one
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (img_we && !page_start) |=> (!img_we || img_addr == $past(img_addr) + 1'b1));

endmodule

// File: rtl/nbf_checksum.sv
module nbf_checksum
    import nbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add_en,
    input  logic [BEAT_W-1:0] data,
    input  logic [WORD_W-1:0] expected,
    output logic              match
);

    logic [WORD_W-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            sum_q <= '0;
        else if (add_en)
            sum_q <= sum_q + beat_word_sum(data);
    end

    assign match = (sum_q == expected);

    // R6: the running sum moves only when a data beat is added
    assert_sum_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!add_en && !clear) |=> $stable(sum_q));

endmodule

// File: rtl/nbf_candidate_ctrl.sv
module nbf_candidate_ctrl
    import nbf_pkg::*;
#(
    parameter int NUM_CAND = 4,
    parameter int CAND_STRIDE = 256,
    parameter int PAGE_AW = 24,
    parameter int RESTART_W = 4,
    localparam int IDX_W = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_ready,
    input  logic                 page_done,
    input  logic                 page_bad,
    input  logic                 sum_match,
    output logic                 req_valid,
    output logic [PAGE_AW-1:0]   req_page,
    output logic                 xfer_active,
    output logic                 page_start,
    output logic                 boot_ok,
    output logic                 boot_fail,
    output logic [RESTART_W-1:0] restart_cnt
);

    localparam logic [IDX_W-1:0]     IDX_LAST = IDX_W'(NUM_CAND - 1);
    localparam logic [RESTART_W-1:0] RST_MAX = {RESTART_W{1'b1}};

    boot_state_e          state_q, state_d;
    logic [IDX_W-1:0]     idx_q, idx_d;
    logic [RESTART_W-1:0] rcnt_q, rcnt_d;
    page_verdict_e        verdict;

    assign verdict = classify(page_bad, sum_match);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        rcnt_d  = rcnt_q;
        unique case (state_q)
            ST_INIT: state_d = ST_REQ;
            ST_REQ: begin
                if (req_ready)
                    state_d = ST_XFER;
            end
            ST_XFER: begin
                if (page_done) begin
                    unique case (verdict)
                        VERDICT_BAD: begin
                            if (idx_q == IDX_LAST) begin
                                state_d = ST_FAIL;
                            end else begin
                                idx_d   = idx_q + 1'b1;
                                state_d = ST_REQ;
                            end
                        end
                        VERDICT_MISMATCH: begin
                            idx_d   = '0;
                            state_d = ST_REQ;
                            if (rcnt_q != RST_MAX)
                                rcnt_d = rcnt_q + 1'b1;
                        end
                        default: state_d = ST_OK;
                    endcase
                end
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            idx_q   <= '0;
            rcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            rcnt_q  <= rcnt_d;
        end
    end

    assign req_valid   = (state_q == ST_REQ);
    assign req_page    = PAGE_AW'(int'(idx_q) * CAND_STRIDE);
    assign xfer_active = (state_q == ST_XFER);
    assign page_start  = req_valid && req_ready;
    assign boot_ok     = (state_q == ST_OK);
    assign boot_fail   = (state_q == ST_FAIL);
    assign restart_cnt = rcnt_q;

    // R8: request held steady under back-pressure
    assert_req_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_page)));

    // R8: no second request while one is outstanding
    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);

    // R2: a rejected page that is not the last leads to the next candidate
    assert_next_cand_R2: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && page_done && page_bad && idx_q != IDX_LAST)
        |=> (req_valid && req_page == $past(req_page) + PAGE_AW'(CAND_STRIDE)));

    // R7: a checksum mismatch restarts at page 0
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && page_done && !page_bad && !sum_match)
        |=> (req_valid && req_page == '0));

    // R7: the restart count never goes down
    assert_rcnt_mono_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (restart_cnt >= $past(restart_cnt)));

    // R4: failure is sticky and silent
    assert_fail_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        boot_fail |=> (boot_fail && !req_valid && !xfer_active));

    // R6: success is sticky
    assert_ok_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        boot_ok |=> (boot_ok && !req_valid));

    // R4: success and failure are exclusive
    assert_ok_fail_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(boot_ok && boot_fail));

endmodule

// File: rtl/nand_boot_fetch.sv
module nand_boot_fetch
    import nbf_pkg::*;
#(
    parameter int NUM_CAND = 4,
    parameter int CAND_STRIDE = 256,
    parameter int PAGE_AW = 24,
    parameter int DATA_BEATS = 256,
    parameter int SPARE_BEATS = 8,
    parameter int RESTART_W = 4,
    localparam int PAGE_BEATS = DATA_BEATS + SPARE_BEATS,
    localparam int IMG_AW = $clog2(DATA_BEATS)
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [PAGE_AW-1:0]   req_page,
    input  logic                 beat_valid,
    output logic                 beat_ready,
    input  logic [63:0]          beat_data,
    input  logic                 page_done,
    input  logic                 page_ecc_fail,
    input  logic [31:0]          exp_csum,
    output logic                 img_we,
    output logic [IMG_AW-1:0]    img_addr,
    output logic [63:0]          img_wdata,
    output logic                 boot_ok,
    output logic                 boot_fail,
    output logic [RESTART_W-1:0] restart_cnt
);

    logic xfer_active;
    logic page_start;
    logic count_ok;
    logic sum_match;
    logic page_bad;

    assign page_bad = page_ecc_fail || !count_ok;

    nbf_candidate_ctrl #(
        .NUM_CAND    (NUM_CAND),
        .CAND_STRIDE (CAND_STRIDE),
        .PAGE_AW     (PAGE_AW),
        .RESTART_W   (RESTART_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_ready   (req_ready),
        .page_done   (page_done),
        .page_bad    (page_bad),
        .sum_match   (sum_match),
        .req_valid   (req_valid),
        .req_page    (req_page),
        .xfer_active (xfer_active),
        .page_start  (page_start),
        .boot_ok     (boot_ok),
        .boot_fail   (boot_fail),
        .restart_cnt (restart_cnt)
    );

    nbf_beat_router #(
        .DATA_BEATS (DATA_BEATS),
        .PAGE_BEATS (PAGE_BEATS)
    ) u_router (
        .clk         (clk),
        .rst         (rst),
        .xfer_active (xfer_active),
        .page_start  (page_start),
        .beat_valid  (beat_valid),
        .beat_data   (beat_data),
        .beat_ready  (beat_ready),
        .img_we      (img_we),
        .img_addr    (img_addr),
        .img_wdata   (img_wdata),
        .count_ok    (count_ok)
    );

    nbf_checksum u_csum (
        .clk      (clk),
        .rst      (rst),
        .clear    (page_start),
        .add_en   (img_we),
        .data     (beat_data),
        .expected (exp_csum),
        .match    (sum_match)
    );

    // R9: nothing is active while reset is held
    always @(posedge clk) begin
        if (rst) begin
            assert_reset_quiet_R9: assert (!img_we);
        end
    end

endmodule

// File: tb/tb_nand_boot_fetch.sv
module tb_nand_boot_fetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [23:0] req_page;
    logic        beat_valid = 1'b0;
    logic        beat_ready;
    logic [63:0] beat_data = '0;
    logic        page_done = 1'b0;
    logic        page_ecc_fail = 1'b0;
    logic [31:0] exp_csum = '0;
    logic        img_we;
    logic [7:0]  img_addr;
    logic [63:0] img_wdata;
    logic        boot_ok;
    logic        boot_fail;
    logic [3:0]  restart_cnt;

    int checks = 0;
    int errors = 0;
    int exp_idx = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nand_boot_fetch dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
        .page_done(page_done), .page_ecc_fail(page_ecc_fail), .exp_csum(exp_csum),
        .img_we(img_we), .img_addr(img_addr), .img_wdata(img_wdata),
        .boot_ok(boot_ok), .boot_fail(boot_fail), .restart_cnt(restart_cnt)
    );

    // page codes: 0 good+match, 1 ECC fail, 2 short (200), 3 long (270), 4 good+mismatch
    localparam int NSCN = 7;
    localparam logic [2:0] SCN_CODES [NSCN][8] = '{
        '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd1, 3'd2, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd1, 3'd1, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd4, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd2, 3'd4, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
        '{3'd1, 3'd3, 3'd2, 3'd4, 3'd1, 3'd2, 3'd3, 3'd1}
    };
    localparam int SCN_LEN  [NSCN] = '{1, 2, 4, 4, 3, 4, 8};
    localparam bit SCN_OK   [NSCN] = '{1, 1, 1, 0, 1, 1, 0};
    localparam bit SCN_FAIL [NSCN] = '{0, 0, 0, 1, 0, 0, 1};
    localparam int SCN_RST  [NSCN] = '{0, 0, 0, 0, 1, 2, 1};

    task automatic chk(input bit cond, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input int seed, input int i);
        return (32'(seed) * 32'h01000193) ^ (32'(i) * 32'h9E3779B1) ^ 32'(i + 5);
    endfunction

    function automatic logic [63:0] beat_val(input int seed, input int b);
        return {mix(seed, 2 * b + 1), mix(seed, 2 * b)};
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        req_ready = 1'b0;
        beat_valid = 1'b0;
        page_done = 1'b0;
        page_ecc_fail = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_idx = 0;
    endtask

    task automatic get_req();
        int w = 0;
        logic [23:0] first;
        while (!req_valid && w < 50) begin
            @(negedge clk);
            w++;
        end
        chk(req_valid, "R1 request raised", req_valid, 1);
        chk(req_page == 24'(exp_idx * 256), "R1 candidate page order", req_page, exp_idx * 256);
        first = req_page;
        repeat (2) @(negedge clk);
        chk(req_valid && req_page == first, "R8 request steady while stalled", req_page, first);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(!req_valid, "R8 single outstanding request", req_valid, 0);
    endtask

    task automatic run_page(input logic [2:0] code, input int seed);
        int nbeats;
        logic [31:0] sum = '0;
        bit wr_ok = 1;
        int nwr = 0;
        nbeats = (code == 3'd2) ? 200 : (code == 3'd3) ? 270 : 264;
        for (int b = 0; b < 256; b++)
            sum += beat_val(seed, b)[31:0] + beat_val(seed, b)[63:32];
        exp_csum = (code == 3'd4) ? sum + 32'd1 : sum;
        get_req();
        for (int b = 0; b < nbeats; b++) begin
            beat_valid = 1'b1;
            beat_data = beat_val(seed, b);
            #1;
            if (b < 256) begin
                if (!(img_we && img_addr == 8'(b) && img_wdata == beat_data)) wr_ok = 0;
            end else if (img_we) wr_ok = 0;
            if (img_we) nwr++;
            @(negedge clk);
        end
        beat_valid = 1'b0;
        chk(wr_ok, "R5 data beats written in order, spare dropped", nwr, (nbeats < 256) ? nbeats : 256);
        page_done = 1'b1;
        page_ecc_fail = (code == 3'd1);
        @(negedge clk);
        page_done = 1'b0;
        page_ecc_fail = 1'b0;
        if (code == 3'd4) begin
            chk(req_valid && req_page == 0, "R7 mismatch restarts at page 0", req_page, 0);
            exp_idx = 0;
        end else if (code == 3'd0) begin
            chk(boot_ok, "R6 checksum match sets boot_ok", boot_ok, 1);
        end else begin
            if (code == 3'd1)
                chk(!boot_ok, "R2 ECC fail rejects page", boot_ok, 0);
            else
                chk(!boot_ok, "R3 wrong beat count rejects page", boot_ok, 0);
            exp_idx++;
        end
    endtask

    task automatic check_idle(input string tag);
        bit quiet = 1;
        for (int i = 0; i < 20; i++) begin
            beat_valid = 1'b1;
            page_done = (i == 5);
            #1;
            if (req_valid || beat_ready || img_we) quiet = 0;
            @(negedge clk);
        end
        beat_valid = 1'b0;
        page_done = 1'b0;
        chk(quiet, tag, {req_valid, beat_ready, img_we}, 0);
    endtask

    initial begin
        // R9: reset state
        repeat (2) @(negedge clk);
        chk(!req_valid && !beat_ready && !img_we, "R9 reset quiet handshakes",
            {req_valid, beat_ready, img_we}, 0);
        chk(!boot_ok && !boot_fail && restart_cnt == 0, "R9 reset status",
            {boot_ok, boot_fail, restart_cnt}, 0);

        for (int s = 0; s < NSCN; s++) begin
            do_reset();
            chk(restart_cnt == 0, "R9 restart count cleared by reset", restart_cnt, 0);
            for (int p = 0; p < SCN_LEN[s]; p++)
                run_page(SCN_CODES[s][p], s * 16 + p);
            chk(boot_ok == SCN_OK[s], "R6 scenario boot_ok", boot_ok, SCN_OK[s]);
            chk(boot_fail == SCN_FAIL[s], "R4 scenario boot_fail", boot_fail, SCN_FAIL[s]);
            chk(restart_cnt == 4'(SCN_RST[s]), "R7 scenario restart count", restart_cnt, SCN_RST[s]);
            if (SCN_FAIL[s]) check_idle("R4 no activity after give-up");
            else check_idle("R6 no activity after success");
            chk(boot_ok == SCN_OK[s] && boot_fail == SCN_FAIL[s], "R4 flags sticky",
                {boot_ok, boot_fail}, {SCN_OK[s], SCN_FAIL[s]});
        end

        // R7: saturation after 17 mismatches
        do_reset();
        for (int p = 0; p < 17; p++)
            run_page(3'd4, 200 + p);
        chk(restart_cnt == 4'd15, "R7 restart count saturates", restart_cnt, 15);
        run_page(3'd0, 300);
        chk(boot_ok && restart_cnt == 4'd15, "R7 saturated count then boot", restart_cnt, 15);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule